// File: doc/BRIEF.md
# AXI4 Slave Memory Responder

This block is an AXI4 slave that serves read and write bursts from an internal word array without any outside control. It occupies a window starting at a base address that is set by a parameter. The size of that window, in bytes, is also a parameter. An address inside the window selects a word of the array. An address outside the window gets a decode error.

A small configuration input sets three timing values, each counted in clock cycles:
- the number of idle cycles after the last write data beat before the write response appears;
- the number of idle cycles after a read address is accepted before the first read beat appears;
- the number of idle cycles between consecutive read beats.

A further flag chooses the reply to a locked (exclusive) access: EXOKAY when the flag is set, OKAY when it is clear.

The block serves aligned, full-width incrementing bursts only. It keeps at most one read burst and one write burst open at any time. Use it as a memory endpoint on an interconnect. Use it also as a target with controllable latency when exercising a master.

Top module: `axmem_responder`

## Requirements
- R1: After synchronous reset, AWREADY and ARREADY are 1, and BVALID and RVALID are 0.
- R2: Beat i of a burst addresses byte address AxADDR + i·(DATA_W/8). Data written at an in-range address is returned by a later read of the same address.
- R3: On a write beat, only the bytes whose WSTRB bit is 1 are changed. Byte lane b is WDATA[8b+7:8b].
- R4: A burst has AxLEN+1 beats, so AxLEN=0 gives one beat. RLAST is 1 on the read beat whose index equals ARLEN, and 0 on every earlier beat.
- R5: With a write gap of g, BVALID first goes high in the clock period g+1 periods after the period in which the WLAST beat is accepted.
- R6: With a first-read gap of g, the first read beat is valid in the period g+1 periods after the period in which the read address is accepted.
- R7: With a beat gap of g and RREADY held high, each further read beat is valid g+1 periods after the previous beat.
- R8: For an in-range access, the response code is as follows. A locked access (AxLOCK=1) gets EXOKAY (2'b01) when the exclusive flag is 1, and OKAY (2'b00) when it is 0. An unlocked access always gets OKAY.
- R9: An address outside [base, base+size) gives DECERR (2'b11), which takes precedence over EXOKAY. On a read, such a beat carries zero data. On a write, such a beat leaves the array unchanged, and the write response is DECERR if any beat of the burst was out of range.
- R10: AWREADY stays 0 from the write-address handshake until the write-response handshake. ARREADY stays 0 from the read-address handshake until the last read beat is accepted.
- R11: BID equals the accepted AWID and RID equals the accepted ARID. BVALID and BRESP hold steady while BREADY is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wr_gap | input | GAP_W | Idle cycles before the write response |
| cfg_rd_first_gap | input | GAP_W | Idle cycles before the first read beat |
| cfg_rd_beat_gap | input | GAP_W | Idle cycles between read beats |
| cfg_excl_en | input | 1 | Exclusive accesses are answered with EXOKAY |
| awid | input | ID_W | Write address ID |
| awaddr | input | ADDR_W | Write burst start address |
| awlen | input | 8 | Write beats minus one |
| awlock | input | 1 | Exclusive write |
| awvalid | input | 1 | Write address valid |
| awready | output | 1 | Write address accepted |
| wdata | input | DATA_W | Write data |
| wstrb | input | DATA_W/8 | Write byte enables |
| wlast | input | 1 | Final write beat |
| wvalid | input | 1 | Write data valid |
| wready | output | 1 | Write data accepted |
| bid | output | ID_W | Write response ID |
| bresp | output | 2 | Write response code |
| bvalid | output | 1 | Write response valid |
| bready | input | 1 | Write response taken |
| arid | input | ID_W | Read address ID |
| araddr | input | ADDR_W | Read burst start address |
| arlen | input | 8 | Read beats minus one |
| arlock | input | 1 | Exclusive read |
| arvalid | input | 1 | Read address valid |
| arready | output | 1 | Read address accepted |
| rid | output | ID_W | Read data ID |
| rdata | output | DATA_W | Read data |
| rresp | output | 2 | Read response code |
| rlast | output | 1 | Final read beat |
| rvalid | output | 1 | Read data valid |
| rready | input | 1 | Read data taken |

## Verification
Each internal state error shows up at the ports soon after it happens:

- **Beat counter.** A wrong value moves RLAST to the wrong beat. This is visible at the final handshake of the same burst.
- **Address counter.** A wrong value returns the wrong stored word on the very next beat.
- **Gap counter.** A stuck or off-by-one counter moves BVALID or RVALID by whole periods. This is visible at the first response after the gap.
- **Out-of-range write.** If a write beat outside the window reaches the array, it corrupts an aliased in-range word. This is only seen when that word is read back, so the test reads word zero right after a burst that runs past the end of the window.

// File: rtl/axmem_pkg.sv
package axmem_pkg;

    typedef enum logic [1:0] {
        RSP_OKAY   = 2'b00,
        RSP_EXOKAY = 2'b01,
        RSP_SLVERR = 2'b10,
        RSP_DECERR = 2'b11
    } axresp_e;

    typedef enum logic [1:0] {
        WR_IDLE,
        WR_DATA,
        WR_GAP,
        WR_RESP
    } wr_state_e;

    typedef enum logic [1:0] {
        RD_IDLE,
        RD_GAP,
        RD_BEAT
    } rd_state_e;

    // Decode error wins over the exclusive reply.
    function automatic axresp_e pick_resp(input logic hit, input logic lock, input logic excl_en);
        if (!hit) begin
            return RSP_DECERR;
        end
        if (lock && excl_en) begin
            return RSP_EXOKAY;
        end
        return RSP_OKAY;
    endfunction

endpackage

// File: rtl/axmem_decode.sv
module axmem_decode #(
    parameter int          ADDR_W    = 32,
    parameter logic [63:0] BASE_ADDR = 64'h0,
    parameter int          MEM_BYTES = 4,
    parameter int          LSB       = 2,
    parameter int          IDX_W     = 1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [IDX_W-1:0]  idx
);
    localparam logic [ADDR_W:0] LO = {1'b0, BASE_ADDR[ADDR_W-1:0]};
    localparam logic [ADDR_W:0] HI = LO + (ADDR_W+1)'(MEM_BYTES);

    logic [ADDR_W:0]   ext;
    logic [ADDR_W-1:0] off;

    assign ext = {1'b0, addr};
    assign hit = (ext >= LO) && (ext < HI);
    assign off = addr - BASE_ADDR[ADDR_W-1:0];
    assign idx = IDX_W'(off >> LSB);
endmodule

// File: rtl/axmem_store.sv
module axmem_store #(
    parameter int DATA_W = 32,
    parameter int WORDS  = 1,
    parameter int IDX_W  = 1
) (
    input  logic                clk,
    input  logic                we,
    input  logic [IDX_W-1:0]    widx,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [DATA_W/8-1:0] wstrb,
    input  logic [IDX_W-1:0]    ridx,
    output logic [DATA_W-1:0]   rdata
);
    localparam int LANES = DATA_W / 8;

    logic [DATA_W-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we) begin
            for (int b = 0; b < LANES; b++) begin
                if (wstrb[b]) begin
                    mem[widx][b*8 +: 8] <= wdata[b*8 +: 8];
                end
            end
        end
    end

    assign rdata = mem[ridx];
endmodule

// File: rtl/axmem_wr_engine.sv
module axmem_wr_engine
    import axmem_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int ID_W   = 4,
    parameter int GAP_W  = 8,
    parameter int BYTES  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [GAP_W-1:0]  cfg_gap,
    input  logic              cfg_excl_en,
    input  logic [ID_W-1:0]   awid,
    input  logic [ADDR_W-1:0] awaddr,
    input  logic              awlock,
    input  logic              awvalid,
    output logic              awready,
    input  logic              wlast,
    input  logic              wvalid,
    output logic              wready,
    output logic [ID_W-1:0]   bid,
    output logic [1:0]        bresp,
    output logic              bvalid,
    input  logic              bready,
    output logic [ADDR_W-1:0] beat_addr,
    input  logic              beat_hit,
    output logic              mem_we
);
    wr_state_e         state;
    logic [ADDR_W-1:0] addr_q;
    logic [ID_W-1:0]   id_q;
    logic              lock_q;
    logic              miss_q;
    logic [GAP_W-1:0]  cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= WR_IDLE;
            addr_q <= '0;
            id_q   <= '0;
            lock_q <= 1'b0;
            miss_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            case (state)
                WR_IDLE: begin
                    if (awvalid) begin
                        addr_q <= awaddr;
                        id_q   <= awid;
                        lock_q <= awlock;
                        miss_q <= 1'b0;
                        state  <= WR_DATA;
                    end
                end
                WR_DATA: begin
                    if (wvalid) begin
                        addr_q <= addr_q + ADDR_W'(BYTES);
                        if (!beat_hit) begin
                            miss_q <= 1'b1;
                        end
                        if (wlast) begin
                            cnt_q <= cfg_gap;
                            state <= (cfg_gap == '0) ? WR_RESP : WR_GAP;
                        end
                    end
                end
                WR_GAP: begin
                    cnt_q <= cnt_q - GAP_W'(1);
                    if (cnt_q == GAP_W'(1)) begin
                        state <= WR_RESP;
                    end
                end
                WR_RESP: begin
                    if (bready) begin
                        state <= WR_IDLE;
                    end
                end
                default: state <= WR_IDLE;
            endcase
        end
    end

    assign awready   = (state == WR_IDLE);
    assign wready    = (state == WR_DATA);
    assign bvalid    = (state == WR_RESP);
    assign bid       = id_q;
    assign bresp     = pick_resp(!miss_q, lock_q, cfg_excl_en);
    assign beat_addr = addr_q;
    assign mem_we    = wready && wvalid && beat_hit;
endmodule

// File: rtl/axmem_rd_engine.sv
module axmem_rd_engine
    import axmem_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int ID_W   = 4,
    parameter int GAP_W  = 8,
    parameter int BYTES  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [GAP_W-1:0]  cfg_first_gap,
    input  logic [GAP_W-1:0]  cfg_beat_gap,
    input  logic              cfg_excl_en,
    input  logic [ID_W-1:0]   arid,
    input  logic [ADDR_W-1:0] araddr,
    input  logic [7:0]        arlen,
    input  logic              arlock,
    input  logic              arvalid,
    output logic              arready,
    output logic [ID_W-1:0]   rid,
    output logic [1:0]        rresp,
    output logic              rlast,
    output logic              rvalid,
    input  logic              rready,
    output logic [ADDR_W-1:0] beat_addr,
    input  logic              beat_hit
);
    rd_state_e         state;
    logic [ADDR_W-1:0] addr_q;
    logic [ID_W-1:0]   id_q;
    logic              lock_q;
    logic [7:0]        len_q;
    logic [7:0]        beat_q;
    logic [GAP_W-1:0]  cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= RD_IDLE;
            addr_q <= '0;
            id_q   <= '0;
            lock_q <= 1'b0;
            len_q  <= '0;
            beat_q <= '0;
            cnt_q  <= '0;
        end else begin
            case (state)
                RD_IDLE: begin
                    if (arvalid) begin
                        addr_q <= araddr;
                        id_q   <= arid;
                        lock_q <= arlock;
                        len_q  <= arlen;
                        beat_q <= '0;
                        cnt_q  <= cfg_first_gap;
                        state  <= (cfg_first_gap == '0) ? RD_BEAT : RD_GAP;
                    end
                end
                RD_GAP: begin
                    cnt_q <= cnt_q - GAP_W'(1);
                    if (cnt_q == GAP_W'(1)) begin
                        state <= RD_BEAT;
                    end
                end
                RD_BEAT: begin
                    if (rready) begin
                        if (beat_q == len_q) begin
                            state <= RD_IDLE;
                        end else begin
                            beat_q <= beat_q + 8'd1;
                            addr_q <= addr_q + ADDR_W'(BYTES);
                            cnt_q  <= cfg_beat_gap;
                            state  <= (cfg_beat_gap == '0) ? RD_BEAT : RD_GAP;
                        end
                    end
                end
                default: state <= RD_IDLE;
            endcase
        end
    end

    assign arready   = (state == RD_IDLE);
    assign rvalid    = (state == RD_BEAT);
    assign rlast     = (beat_q == len_q);
    assign rid       = id_q;
    assign rresp     = pick_resp(beat_hit, lock_q, cfg_excl_en);
    assign beat_addr = addr_q;
endmodule

// File: rtl/axmem_responder.sv
module axmem_responder #(
    parameter int          DATA_W    = 32,
    parameter int          ADDR_W    = 32,
    parameter int          ID_W      = 4,
    parameter int          GAP_W     = 8,
    parameter logic [63:0] BASE_ADDR = 64'h0,
    parameter int          MEM_BYTES = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [GAP_W-1:0]    cfg_wr_gap,
    input  logic [GAP_W-1:0]    cfg_rd_first_gap,
    input  logic [GAP_W-1:0]    cfg_rd_beat_gap,
    input  logic                cfg_excl_en,
    input  logic [ID_W-1:0]     awid,
    input  logic [ADDR_W-1:0]   awaddr,
    input  logic [7:0]          awlen,
    input  logic                awlock,
    input  logic                awvalid,
    output logic                awready,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [DATA_W/8-1:0] wstrb,
    input  logic                wlast,
    input  logic                wvalid,
    output logic                wready,
    output logic [ID_W-1:0]     bid,
    output logic [1:0]          bresp,
    output logic                bvalid,
    input  logic                bready,
    input  logic [ID_W-1:0]     arid,
    input  logic [ADDR_W-1:0]   araddr,
    input  logic [7:0]          arlen,
    input  logic                arlock,
    input  logic                arvalid,
    output logic                arready,
    output logic [ID_W-1:0]     rid,
    output logic [DATA_W-1:0]   rdata,
    output logic [1:0]          rresp,
    output logic                rlast,
    output logic                rvalid,
    input  logic                rready
);
    localparam int BYTES = DATA_W / 8;
    localparam int LSB   = $clog2(BYTES);
    localparam int WORDS = (MEM_BYTES / BYTES > 0) ? MEM_BYTES / BYTES : 1;
    localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;

    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic              wr_hit, rd_hit;
    logic [IDX_W-1:0]  wr_idx, rd_idx;
    logic              mem_we;
    logic [DATA_W-1:0] mem_rdata;

    axmem_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .MEM_BYTES(MEM_BYTES),
                   .LSB(LSB), .IDX_W(IDX_W)) u_wr_dec (
        .addr(wr_addr), .hit(wr_hit), .idx(wr_idx)
    );

    axmem_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .MEM_BYTES(MEM_BYTES),
                   .LSB(LSB), .IDX_W(IDX_W)) u_rd_dec (
        .addr(rd_addr), .hit(rd_hit), .idx(rd_idx)
    );

    axmem_store #(.DATA_W(DATA_W), .WORDS(WORDS), .IDX_W(IDX_W)) u_store (
        .clk(clk), .we(mem_we), .widx(wr_idx), .wdata(wdata), .wstrb(wstrb),
        .ridx(rd_idx), .rdata(mem_rdata)
    );

    axmem_wr_engine #(.ADDR_W(ADDR_W), .ID_W(ID_W), .GAP_W(GAP_W), .BYTES(BYTES)) u_wr (
        .clk(clk), .rst(rst), .cfg_gap(cfg_wr_gap), .cfg_excl_en(cfg_excl_en),
        .awid(awid), .awaddr(awaddr), .awlock(awlock), .awvalid(awvalid), .awready(awready),
        .wlast(wlast), .wvalid(wvalid), .wready(wready),
        .bid(bid), .bresp(bresp), .bvalid(bvalid), .bready(bready),
        .beat_addr(wr_addr), .beat_hit(wr_hit), .mem_we(mem_we)
    );

    axmem_rd_engine #(.ADDR_W(ADDR_W), .ID_W(ID_W), .GAP_W(GAP_W), .BYTES(BYTES)) u_rd (
        .clk(clk), .rst(rst), .cfg_first_gap(cfg_rd_first_gap), .cfg_beat_gap(cfg_rd_beat_gap),
        .cfg_excl_en(cfg_excl_en),
        .arid(arid), .araddr(araddr), .arlen(arlen), .arlock(arlock),
        .arvalid(arvalid), .arready(arready),
        .rid(rid), .rresp(rresp), .rlast(rlast), .rvalid(rvalid), .rready(rready),
        .beat_addr(rd_addr), .beat_hit(rd_hit)
    );

    // Beat count vs. length is tracked by the write side through WLAST only.
    logic unused_awlen;
    assign unused_awlen = ^awlen;

    assign rdata = rd_hit ? mem_rdata : '0;
endmodule

// File: rtl/axmem_responder_chk.sv
module axmem_responder_chk #(
    parameter int DATA_W = 32,
    parameter int ID_W   = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_excl_en,
    input logic              awvalid,
    input logic              awready,
    input logic              wvalid,
    input logic              wready,
    input logic              wlast,
    input logic [ID_W-1:0]   bid,
    input logic [1:0]        bresp,
    input logic              bvalid,
    input logic              bready,
    input logic [7:0]        arlen,
    input logic              arvalid,
    input logic              arready,
    input logic [DATA_W-1:0] rdata,
    input logic [1:0]        rresp,
    input logic              rlast,
    input logic              rvalid,
    input logic              rready
);
    logic       wr_open, wlast_seen, rd_open;
    logic [7:0] rd_len, rd_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_open    <= 1'b0;
            wlast_seen <= 1'b0;
            rd_open    <= 1'b0;
            rd_len     <= '0;
            rd_cnt     <= '0;
        end else begin
            if (awvalid && awready) begin
                wr_open <= 1'b1;
            end else if (bvalid && bready) begin
                wr_open <= 1'b0;
            end
            if (wvalid && wready && wlast) begin
                wlast_seen <= 1'b1;
            end else if (bvalid && bready) begin
                wlast_seen <= 1'b0;
            end
            if (arvalid && arready) begin
                rd_open <= 1'b1;
                rd_len  <= arlen;
                rd_cnt  <= '0;
            end else if (rvalid && rready) begin
                rd_cnt <= rd_cnt + 8'd1;
                if (rlast) begin
                    rd_open <= 1'b0;
                end
            end
        end
    end

    AST_AW_HELD_OPEN: assert property (@(posedge clk) disable iff (rst)
        wr_open |-> !awready); // R10
    AST_AR_HELD_OPEN: assert property (@(posedge clk) disable iff (rst)
        rd_open |-> !arready); // R10
    AST_B_AFTER_WLAST: assert property (@(posedge clk) disable iff (rst)
        bvalid |-> wlast_seen); // R5
    AST_R_ONLY_OPEN: assert property (@(posedge clk) disable iff (rst)
        rvalid |-> rd_open); // R6
    AST_RLAST_AT_LEN: assert property (@(posedge clk) disable iff (rst)
        rvalid |-> (rlast == (rd_cnt == rd_len))); // R4
    AST_DECERR_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rvalid && rresp == 2'b11) |-> (rdata == '0)); // R9
    AST_EXOKAY_ENABLED: assert property (@(posedge clk) disable iff (rst)
        (rvalid && rresp == 2'b01) |-> cfg_excl_en); // R8
    AST_B_HOLD: assert property (@(posedge clk) disable iff (rst)
        (bvalid && !bready) |=> (bvalid && $stable(bresp) && $stable(bid))); // R11
endmodule

bind axmem_responder axmem_responder_chk #(.DATA_W(DATA_W), .ID_W(ID_W)) u_chk (
    .clk(clk), .rst(rst), .cfg_excl_en(cfg_excl_en),
    .awvalid(awvalid), .awready(awready),
    .wvalid(wvalid), .wready(wready), .wlast(wlast),
    .bid(bid), .bresp(bresp), .bvalid(bvalid), .bready(bready),
    .arlen(arlen), .arvalid(arvalid), .arready(arready),
    .rdata(rdata), .rresp(rresp), .rlast(rlast), .rvalid(rvalid), .rready(rready)
);

// File: tb/axmem_responder_tb.sv
module axmem_responder_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] BASE = 32'h1000;
    localparam int SIZE = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  cfg_wr_gap = '0, cfg_rd_first_gap = '0, cfg_rd_beat_gap = '0;
    logic        cfg_excl_en = 1'b1;
    logic [3:0]  awid = '0, arid = '0;
    logic [31:0] awaddr = '0, araddr = '0;
    logic [7:0]  awlen = '0, arlen = '0;
    logic        awlock = 1'b0, arlock = 1'b0, awvalid = 1'b0, arvalid = 1'b0;
    logic [31:0] wdata = '0;
    logic [3:0]  wstrb = '0;
    logic        wlast = 1'b0, wvalid = 1'b0;
    logic        bready = 1'b1, rready = 1'b1;
    logic        awready, wready, bvalid, arready, rvalid, rlast;
    logic [3:0]  bid, rid;
    logic [1:0]  bresp, rresp;
    logic [31:0] rdata;

    int nchk = 0, nfail = 0, cyc = 0;

    typedef struct { logic [3:0] id; logic [1:0] resp; logic [31:0] data; logic last; int period; string tag; } rexp_t;
    typedef struct { logic [3:0] id; logic [1:0] resp; int period; string tag; } bexp_t;
    rexp_t rq[$];
    bexp_t bq[$];
    logic [31:0] mref [SIZE/4];

    axmem_responder #(.DATA_W(32), .ADDR_W(32), .ID_W(4), .GAP_W(8),
                      .BASE_ADDR(64'h1000), .MEM_BYTES(SIZE)) u_dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic bit in_win(input logic [31:0] a);
        return (a >= BASE) && (a < BASE + SIZE);
    endfunction

    task automatic chk1(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Monitor: write responses
    always @(negedge clk) begin
        bexp_t e;
        if (!rst && bvalid) begin
            nchk++;
            if (bq.size() == 0) begin
                nfail++;
                $display("FAIL R10 unexpected B: bid=%0d bresp=%0d expected none", bid, bresp);
            end else begin
                e = bq.pop_front();
                if (bid !== e.id || bresp !== e.resp || cyc != e.period) begin
                    nfail++;
                    $display("FAIL %s B: id=%0d resp=%0d period=%0d expected id=%0d resp=%0d period=%0d",
                             e.tag, bid, bresp, cyc, e.id, e.resp, e.period);
                end
            end
        end
    end

    // Monitor: read beats
    always @(negedge clk) begin
        rexp_t e;
        if (!rst && rvalid) begin
            nchk++;
            if (rq.size() == 0) begin
                nfail++;
                $display("FAIL R10 unexpected R: rdata=%h expected none", rdata);
            end else begin
                e = rq.pop_front();
                if (rid !== e.id || rresp !== e.resp || rdata !== e.data || rlast !== e.last || cyc != e.period) begin
                    nfail++;
                    $display("FAIL %s R: id=%0d resp=%0d data=%h last=%b period=%0d expected id=%0d resp=%0d data=%h last=%b period=%0d",
                             e.tag, rid, rresp, rdata, rlast, cyc, e.id, e.resp, e.data, e.last, e.period);
                end
            end
        end
    end

    task automatic do_write(input logic [3:0] id, input logic [31:0] addr, input int len,
                            input logic [3:0] strb, input logic lock, input string tag);
        int wl_period;
        bit miss;
        bexp_t e;
        miss = 0;
        wl_period = 0;
        @(posedge clk); #1;
        awvalid = 1'b1; awid = id; awaddr = addr; awlen = 8'(len); awlock = lock;
        do @(negedge clk); while (!awready);
        @(posedge clk); #1;
        awvalid = 1'b0;
        for (int i = 0; i <= len; i++) begin
            logic [31:0] a;
            logic [31:0] d;
            a = addr + 32'(i * 4);
            d = {id, 4'hA, 8'(i), a[15:0]};
            wvalid = 1'b1; wdata = d; wstrb = strb; wlast = (i == len);
            do @(negedge clk); while (!wready);
            if (i == 0) chk1(awready == 1'b0, "R10 awready low during write", 32'(awready), 0);
            wl_period = cyc;
            if (in_win(a)) begin
                for (int b = 0; b < 4; b++)
                    if (strb[b]) mref[(a - BASE) >> 2][b*8 +: 8] = d[b*8 +: 8];
            end else begin
                miss = 1;
            end
            @(posedge clk); #1;
        end
        wvalid = 1'b0; wlast = 1'b0;
        e.id = id;
        e.resp = miss ? 2'b11 : ((lock && cfg_excl_en) ? 2'b01 : 2'b00);
        e.period = wl_period + int'(cfg_wr_gap) + 1;
        e.tag = tag;
        bq.push_back(e);
        while (bq.size() != 0) @(negedge clk);
        @(negedge clk);
        chk1(awready == 1'b1, "R10 awready back after B", 32'(awready), 1);
    endtask

    task automatic do_read(input logic [3:0] id, input logic [31:0] addr, input int len,
                           input logic lock, input string tag);
        int p;
        @(posedge clk); #1;
        arvalid = 1'b1; arid = id; araddr = addr; arlen = 8'(len); arlock = lock;
        do @(negedge clk); while (!arready);
        p = cyc;
        for (int i = 0; i <= len; i++) begin
            rexp_t e;
            logic [31:0] a;
            a = addr + 32'(i * 4);
            e.id = id;
            e.period = (i == 0) ? p + int'(cfg_rd_first_gap) + 1 : p + int'(cfg_rd_beat_gap) + 1;
            p = e.period;
            e.data = in_win(a) ? mref[(a - BASE) >> 2] : 32'h0;
            e.resp = !in_win(a) ? 2'b11 : ((lock && cfg_excl_en) ? 2'b01 : 2'b00);
            e.last = (i == len);
            e.tag = tag;
            rq.push_back(e);
        end
        @(posedge clk); #1;
        arvalid = 1'b0;
        @(negedge clk);
        chk1(arready == 1'b0, "R10 arready low during read", 32'(arready), 0);
        while (rq.size() != 0) @(negedge clk);
        @(negedge clk);
        chk1(arready == 1'b1, "R10 arready back after last beat", 32'(arready), 1);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        nchk++; nfail++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk1(awready === 1'b1 && arready === 1'b1 && bvalid === 1'b0 && rvalid === 1'b0,
             "R1 reset state", {28'h0, awready, arready, bvalid, rvalid}, 32'hC);

        // R2 R4 R11: multi-beat write then read, no gaps
        do_write(4'd3, 32'h1000, 3, 4'hF, 1'b0, "R2 R11 write burst");
        do_read(4'd5, 32'h1000, 3, 1'b0, "R2 R4 R11 read burst");

        // R3 R4: single beat, partial strobe
        do_write(4'd1, 32'h1008, 0, 4'b0101, 1'b0, "R3 strobe write");
        do_read(4'd2, 32'h1008, 0, 1'b0, "R3 R4 single beat read");

        // R5 R6 R7: gaps
        cfg_wr_gap = 8'd3; cfg_rd_first_gap = 8'd2; cfg_rd_beat_gap = 8'd1;
        do_write(4'd6, 32'h1020, 2, 4'hF, 1'b0, "R5 write gap");
        do_read(4'd7, 32'h1020, 2, 1'b0, "R6 R7 read gaps");
        cfg_wr_gap = 8'd1; cfg_rd_first_gap = 8'd0; cfg_rd_beat_gap = 8'd4;
        do_read(4'd8, 32'h1000, 1, 1'b0, "R7 beat gap only");
        cfg_wr_gap = 8'd0; cfg_rd_first_gap = 8'd0; cfg_rd_beat_gap = 8'd0;

        // R8: exclusive replies
        cfg_excl_en = 1'b1;
        do_write(4'd9, 32'h1010, 1, 4'hF, 1'b1, "R8 exclusive write enabled");
        do_read(4'd9, 32'h1010, 1, 1'b1, "R8 exclusive read enabled");
        cfg_excl_en = 1'b0;
        do_write(4'd10, 32'h1018, 0, 4'hF, 1'b1, "R8 exclusive write disabled");
        do_read(4'd10, 32'h1010, 1, 1'b1, "R8 exclusive read disabled");
        cfg_excl_en = 1'b1;

        // R9: out of range
        do_write(4'd11, 32'h0FF0, 1, 4'hF, 1'b0, "R9 write below window");
        do_write(4'd12, 32'h1038, 3, 4'hF, 1'b1, "R9 write past end");
        do_read(4'd13, 32'h1038, 3, 1'b0, "R9 read past end");
        do_read(4'd14, 32'h1000, 0, 1'b0, "R9 word zero unaltered");
        do_read(4'd15, 32'h2000, 0, 1'b1, "R9 R8 decerr beats exclusive");

        repeat (3) @(negedge clk);
        chk1(bq.size() == 0 && rq.size() == 0, "R10 no pending responses",
             32'(bq.size() + rq.size()), 0);
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule